// File: doc/BRIEF.md
# Three-Channel Timer Host Register Interface

This block is the processor-side front end of a timer with three independent down-counting channels. A host addresses it through an active-low chip select, a two-bit address and separate active-low read and write strobes on an 8-bit data bus. Addresses 0 to 2 are the three channel data ports. Address 3 is one control port that all channels share. The strobes are sampled on the system clock, and each strobe counts as exactly one bus access however long it is held.

A control byte names one channel and sets three things for it: its counting mode, whether it counts in binary or BCD, and how its 16-bit values are split into bytes. After that, bytes written to the channel's data port are assembled into a divisor. When the divisor is complete, it is presented to the counting logic together with a one-cycle load pulse. Reads return the channel's live count, or a frozen copy of it taken by a latch command, using the same byte sequencing. The counting itself lies outside this block; the block only takes each channel's current count as an input.

Top module: `tmr_host_if`

## Requirements
- R1: A write takes effect only when `cs_n` and `wr_n` are both low. Address values 0, 1 and 2 select the data ports of channels 0, 1 and 2, and address value 3 selects the control port.
- R2: Control byte layout: bits 7:6 channel number, bits 5:4 access kind (00 latch, 01 low byte only, 10 high byte only, 11 low then high), bits 3:1 mode, bit 0 BCD flag. A non-latch control byte updates `ch_mode` and `ch_bcd` of the named channel only. A channel number of 3 has no effect on any channel.
- R3: Until a channel has received a non-latch control byte, data writes to it change neither `ch_div` nor `ch_ready` and produce no `ch_load`.
- R4: With access 11, the first data byte is the low half and the second is the high half. Only the second byte updates `ch_div` to {high, low}, sets `ch_ready` and raises `ch_load` for exactly one cycle.
- R5: With access 01, each data byte loads {00, byte}. With access 10, each data byte loads {byte, 00}. Each such write is a complete load.
- R6: A non-latch control byte clears that channel's `ch_ready` and resets both its write and read byte pointers to the low half.
- R7: Reads of a channel data port return a byte of its 16-bit count on `ch_count`: always the low byte for access 01, always the high byte for access 10, and alternately low then high for access 11, starting with low.
- R8: A latch command (access 00) copies the channel's count into a holding register when the channel holds no latched value. Reads then return the held value in the channel's byte order until it has been fully read, and after that reads follow the live count again. A latch command while a value is already held is ignored.
- R9: `dout_oe` is high and `dout` carries data only while `cs_n` and `rd_n` are both low. Otherwise both are zero. A read of address 3 returns 00.
- R10: After reset every channel is unconfigured, with `ch_mode`, `ch_bcd`, `ch_div`, `ch_ready` and `ch_load` all zero.
- R11: Configuring or loading one channel leaves the other channels' mode, BCD flag, divisor and ready state unchanged.
- R12: A write strobe held low for several clock cycles is taken as a single byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port address: 0-2 channel data, 3 control |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, zero when not driven |
| dout_oe | output | 1 | High while the block drives the read data |
| ch_count | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ch_mode | output | 9 | 3-bit mode per channel |
| ch_bcd | output | 3 | BCD counting flag per channel |
| ch_ready | output | 3 | Channel is configured and holds a complete divisor |
| ch_div | output | 48 | 16-bit divisor per channel |
| ch_load | output | 3 | One-cycle pulse when a channel's divisor is complete |

## Verification
The assertions check four things on every cycle: the read bus stays quiet outside a selected read, and control-port reads return zero. A held strobe yields one write event. A load pulse only follows a data write to that channel. Mode and divisor outputs change only right after a control or load event. The order in which bytes are assembled or returned, the freezing and release of latched counts, the ignoring of writes to unconfigured channels, and the effect of a channel number of 3 all depend on earlier accesses. Those are shown by the bench's access sequences, which compare divisors, read bytes and load-pulse counts against values worked out by hand.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 16;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  // Field order matters: channel select is decoded from the top bits.
  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [BYTE_W-1:0] b);
    return ctl_t'(b);
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [COUNT_W-1:0] v,
                                                  input logic hi);
    return hi ? v[COUNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic reads_high(input acc_e acc, input logic ptr_hi);
    return (acc == ACC_HI) || ((acc == ACC_LOHI) && ptr_hi);
  endfunction
endpackage

// File: rtl/tmr_bus_decode.sv
`timescale 1ns/1ps
module tmr_bus_decode #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  output logic           wr_evt,
  output logic           ctl_evt,
  output logic [NCH-1:0] dat_wr,
  output logic           rd_active,
  output logic [NCH-1:0] rd_done
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

  logic wr_sel, wr_sel_q, rd_act_q, rd_end;
  logic [AW-1:0] rd_addr_q;

  assign wr_sel    = ~cs_n & ~wr_n;
  assign rd_active = ~cs_n & ~rd_n;
  assign wr_evt    = wr_sel & ~wr_sel_q;
  assign rd_end    = rd_act_q & ~rd_active;
  assign ctl_evt   = wr_evt && (addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      wr_sel_q <= wr_sel;
      rd_act_q <= rd_active;
      if (rd_active) rd_addr_q <= addr;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_port
    assign dat_wr[i]  = wr_evt && (addr == AW'(i));
    assign rd_done[i] = rd_end && (rd_addr_q == AW'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_evt,
  input  ctl_t               ctl,
  input  logic               dat_wr,
  input  logic [BYTE_W-1:0]  din,
  input  logic               rd_done,
  input  logic [COUNT_W-1:0] count,
  output logic [2:0]         mode,
  output logic               bcd,
  output logic               ready,
  output logic [COUNT_W-1:0] div,
  output logic               load,
  output logic [BYTE_W-1:0]  rd_byte
);
  logic               cfg_hit, is_cfg, is_latch;
  acc_e               acc_q;
  logic               init_q, wr_hi_q, rd_hi_q, lat_v_q;
  logic [BYTE_W-1:0]  lo_q;
  logic [COUNT_W-1:0] lat_q;

  assign cfg_hit  = ctl_evt && (ctl.sel == 2'(IDX));
  assign is_latch = cfg_hit && (ctl.acc == ACC_LATCH);
  assign is_cfg   = cfg_hit && (ctl.acc != ACC_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      bcd     <= 1'b0;
      acc_q   <= ACC_LATCH;
      init_q  <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      lo_q    <= '0;
      div     <= '0;
      ready   <= 1'b0;
      load    <= 1'b0;
      lat_v_q <= 1'b0;
      lat_q   <= '0;
    end else begin
      load <= 1'b0;
      if (is_cfg) begin
        mode    <= ctl.mode;
        bcd     <= ctl.bcd;
        acc_q   <= ctl.acc;
        init_q  <= 1'b1;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
        ready   <= 1'b0;
        lat_v_q <= 1'b0;
      end else begin
        if (is_latch && !lat_v_q) begin
          lat_v_q <= 1'b1;
          lat_q   <= count;
          rd_hi_q <= 1'b0;
        end
        if (dat_wr && init_q) begin
          unique case (acc_q)
            ACC_LO: begin
              div   <= {{BYTE_W{1'b0}}, din};
              load  <= 1'b1;
              ready <= 1'b1;
            end
            ACC_HI: begin
              div   <= {din, {BYTE_W{1'b0}}};
              load  <= 1'b1;
              ready <= 1'b1;
            end
            ACC_LOHI: begin
              if (!wr_hi_q) begin
                lo_q    <= din;
                wr_hi_q <= 1'b1;
              end else begin
                div     <= {din, lo_q};
                wr_hi_q <= 1'b0;
                load    <= 1'b1;
                ready   <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (rd_done) begin
          if (acc_q == ACC_LOHI) begin
            rd_hi_q <= ~rd_hi_q;
            if (rd_hi_q) lat_v_q <= 1'b0;
          end else begin
            lat_v_q <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_byte = pick_byte(lat_v_q ? lat_q : count, reads_high(acc_q, rd_hi_q));
endmodule

// File: rtl/tmr_rd_mux.sv
`timescale 1ns/1ps
module tmr_rd_mux #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8
) (
  input  logic            rd_active,
  input  logic [AW-1:0]   addr,
  input  logic [NCH*BW-1:0] bytes,
  output logic [BW-1:0]   dout,
  output logic            dout_oe
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_active && (addr == AW'(i))) dout = bytes[i*BW +: BW];
    end
  end
  assign dout_oe = rd_active;
endmodule

// File: rtl/tmr_host_if.sv
`timescale 1ns/1ps
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [1:0]             addr,
  input  logic [BYTE_W-1:0]      din,
  output logic [BYTE_W-1:0]      dout,
  output logic                   dout_oe,
  input  logic [NCH*COUNT_W-1:0] ch_count,
  output logic [NCH*3-1:0]       ch_mode,
  output logic [NCH-1:0]         ch_bcd,
  output logic [NCH-1:0]         ch_ready,
  output logic [NCH*COUNT_W-1:0] ch_div,
  output logic [NCH-1:0]         ch_load
);
  localparam int AW = 2;

  logic              wr_evt, ctl_evt, rd_active;
  logic [NCH-1:0]    dat_wr, rd_done;
  logic [NCH*BYTE_W-1:0] rd_bytes;
  ctl_t              ctl;

  assign ctl = ctl_decode(din);

  tmr_bus_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wr_evt(wr_evt), .ctl_evt(ctl_evt), .dat_wr(dat_wr),
    .rd_active(rd_active), .rd_done(rd_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_regs #(.IDX(i)) u_ch (
      .clk(clk), .rst_n(rst_n), .ctl_evt(ctl_evt), .ctl(ctl),
      .dat_wr(dat_wr[i]), .din(din), .rd_done(rd_done[i]),
      .count(ch_count[i*COUNT_W +: COUNT_W]),
      .mode(ch_mode[i*3 +: 3]), .bcd(ch_bcd[i]), .ready(ch_ready[i]),
      .div(ch_div[i*COUNT_W +: COUNT_W]), .load(ch_load[i]),
      .rd_byte(rd_bytes[i*BYTE_W +: BYTE_W])
    );
  end

  tmr_rd_mux #(.NCH(NCH), .AW(AW), .BW(BYTE_W)) u_mux (
    .rd_active(rd_active), .addr(addr), .bytes(rd_bytes),
    .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/tmr_host_if_chk.sv
`timescale 1ns/1ps
module tmr_host_if_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic [1:0]       addr,
  input logic [7:0]       dout,
  input logic             dout_oe,
  input logic [NCH*3-1:0] ch_mode,
  input logic [NCH-1:0]   ch_ready,
  input logic [NCH*16-1:0] ch_div,
  input logic [NCH-1:0]   ch_load,
  input logic             wr_evt,
  input logic             ctl_evt
);
  a_r9_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!dout_oe && dout == 8'h00));

  a_r9_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == 2'd3) |-> (dout_oe && dout == 8'h00));

  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(wr_evt && addr == 2'(i)));

    a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_load[i] |-> $stable(ch_div[i*16 +: 16]));

    a_r3_ready_by_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ready[i]) |-> ch_load[i]);

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_evt) |-> $stable(ch_mode[i*3 +: 3]));
  end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_tmr_host_if.sv
`timescale 1ns/1ps
module sim_tmr_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        dout_oe;
  logic [47:0] ch_count = 48'h0;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_ready, ch_load;
  logic [47:0] ch_div;

  int total = 0, bad = 0;
  int lc0 = 0, lc1 = 0, lc2 = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tmr_host_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ch_count(ch_count), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
    .ch_ready(ch_ready), .ch_div(ch_div), .ch_load(ch_load)
  );

  always @(posedge clk) begin
    if (ch_load[0]) lc0++;
    if (ch_load[1]) lc1++;
    if (ch_load[2]) lc2++;
  end

  // {op,addr} nibble (0 = write, 1 = read), data byte, expected read byte
  localparam logic [19:0] VEC [0:13] = '{
    20'h3_36_00, 20'h0_34_00, 20'h0_12_00, 20'h4_00_B2, 20'h4_00_A1,
    20'h4_00_B2, 20'h7_00_00, 20'h3_50_00, 20'h5_00_34, 20'h5_00_34,
    20'h3_A5_00, 20'h6_00_0F, 20'h2_77_00, 20'h1_99_00
  };

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk); d = dout; oe = dout_oe; rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic       oe;
    int         l0, l1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ready", 48'(ch_ready), 48'h0);
    check("R10 div", ch_div, 48'h0);
    check("R10 mode/bcd", 48'({ch_mode, ch_bcd}), 48'h0);
    check("R10 load", 48'(ch_load), 48'h0);
    check("R9 idle bus", 48'({dout_oe, dout}), 48'h0);

    // R3 write to unconfigured channel
    bus_write(2'd0, 8'h55);
    check("R3 div0 untouched", 48'({ch_ready[0], ch_div[15:0]}), 48'h0);
    check("R3 no load", 48'(lc0), 48'h0);

    ch_count = {16'h0F0E, 16'h1234, 16'hA1B2};
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][19]) ;
      if (VEC[i][18]) begin
        bus_read(VEC[i][17:16], rb, oe);
        check($sformatf("R7 table read %0d", i), 48'({oe, rb}), 48'({1'b1, VEC[i][7:0]}));
      end else begin
        bus_write(VEC[i][17:16], VEC[i][15:8]);
      end
    end
    // R4 R5 R2 R11 results of the table
    check("R4 div0 low-then-high", 48'(ch_div[15:0]), 48'h1234);
    check("R5 div1 low only", 48'(ch_div[31:16]), 48'h0099);
    check("R5 div2 high only", 48'(ch_div[47:32]), 48'h7700);
    check("R2 modes", 48'(ch_mode), 48'({3'd2, 3'd0, 3'd3}));
    check("R2 bcd", 48'(ch_bcd), 48'b100);
    check("R11 ready all", 48'(ch_ready), 48'b111);
    check("R4 one load each", 48'({lc2[7:0], lc1[7:0], lc0[7:0]}), 48'h010101);

    // R6 control write clears ready and the byte pointer
    bus_write(2'd3, 8'h36);
    check("R6 ready cleared", 48'(ch_ready), 48'b110);
    bus_write(2'd0, 8'hAA);
    check("R4 no load after low byte", 48'(lc0), 48'd1);
    check("R4 div0 held", 48'(ch_div[15:0]), 48'h1234);
    bus_write(2'd3, 8'h36);
    bus_write(2'd0, 8'h11);
    bus_write(2'd0, 8'h22);
    check("R6 pointer restart", 48'(ch_div[15:0]), 48'h2211);
    check("R4 load pulse count", 48'(lc0), 48'd2);
    check("R11 others intact", 48'(ch_div[47:16]), 48'h7700_0099);

    // R12 held strobe
    l1 = lc1;
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 2'd1; din = 8'h42;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R12 held strobe div", 48'(ch_div[31:16]), 48'h0042);
    check("R12 held strobe loads", 48'(lc1 - l1), 48'd1);

    // R1 chip select gating
    l0 = lc0;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    check("R9 no drive without cs", 48'({dout_oe, dout}), 48'h0);
    rd_n = 1'b1;
    @(negedge clk);
    check("R1 write ignored without cs", 48'({lc0 - l0, 16'(ch_div[15:0])}), 48'h2211);

    // R2 channel number 3 ignored
    bus_write(2'd3, 8'hF6);
    check("R2 sel3 modes", 48'({ch_mode, ch_bcd, ch_ready}), 48'({3'd2, 3'd0, 3'd3, 3'b100, 3'b111}));

    // R8 latch on channel 0 (low-then-high)
    bus_write(2'd3, 8'h00);
    ch_count[15:0] = 16'h5555;
    bus_read(2'd0, rb, oe);
    check("R8 latched low", 48'(rb), 48'hB2);
    ch_count[15:0] = 16'h6666;
    bus_write(2'd3, 8'h00);
    bus_read(2'd0, rb, oe);
    check("R8 latched high, relatch ignored", 48'(rb), 48'hA1);
    bus_read(2'd0, rb, oe);
    check("R8 live low after release", 48'(rb), 48'h66);
    bus_read(2'd0, rb, oe);
    check("R7 live high", 48'(rb), 48'h66);

    // R8 latch on channel 1 (low only)
    bus_write(2'd3, 8'h40);
    ch_count[31:16] = 16'h4321;
    bus_read(2'd1, rb, oe);
    check("R8 ch1 latched", 48'(rb), 48'h34);
    bus_read(2'd1, rb, oe);
    check("R8 ch1 released", 48'(rb), 48'h21);

    // R9 control port read
    bus_read(2'd3, rb, oe);
    check("R9 ctl read", 48'({oe, rb}), 48'h100);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule